// File: doc/BRIEF.md
# HCI H4 Packet Deframer

The deframer sits on the receive side of a byte-serial host controller link that uses the H4 framing. Bytes arrive one at a time on a valid/ready stream. Each frame opens with a single type byte. The type byte picks how many header bytes follow and where the payload length sits in that header. The block stores every byte after the type byte in an internal packet buffer. It works out the full frame size from the header and raises a one-cycle completion strobe when the last payload byte has been taken in.

Downstream logic learns of a finished packet from the strobe, which comes with the type code and the stored length (header plus payload, type byte excluded). It then reads the stored bytes through a combinational read port. A type byte the block does not recognise is thrown away. A frame whose header announces more bytes than the buffer can hold is abandoned as soon as its header is complete. In both cases the parser goes back to hunting for a type byte, so a corrupted stream recovers by itself.

Top module: `hci_h4_deframer`

## Requirements
- R1: While rst_n is low, pkt_valid and in_ready are 0. From the first clock edge after reset is released, in_ready is 1 and the parser waits for a type byte.
- R2: Type byte 0x04 (event) is followed by a 2-byte header. The second header byte is the payload length N, and the completed packet reports pkt_len = 2 + N.
- R3: Type byte 0x02 (ACL data) is followed by a 4-byte header. Header bytes at offsets 2 (low) and 3 (high) hold the payload length L in little-endian order, and the completed packet reports pkt_len = 4 + L.
- R4: A type byte other than 0x04 or 0x02 is discarded with no strobe, and the byte after it is again treated as a type byte.
- R5: If header size plus announced payload length exceeds BUF_BYTES (default 1024), no strobe is raised and the byte after the last header byte is treated as a type byte. A total of exactly BUF_BYTES is accepted.
- R6: pkt_valid is high for exactly one cycle, in the cycle after the clock edge that takes in the final byte of the frame. In that cycle pkt_type carries the frame's type code.
- R7: After a strobe, buffer address i (read on rd_data for rd_addr = i) holds the i-th byte after the type byte, header bytes first, until a later frame's bytes overwrite it.
- R8: A packet whose announced payload length is zero completes straight after its last header byte, with pkt_len equal to the header size.
- R9: A byte is taken in only on a clock edge where in_valid and in_ready are both 1. Idle cycles in the middle of a frame change neither the frame's content nor its completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input byte present |
| in_data | input | 8 | Input byte |
| in_ready | output | 1 | Deframer accepts a byte |
| pkt_valid | output | 1 | One-cycle strobe: a complete packet is stored |
| pkt_type | output | 8 | Type code of the completed packet |
| pkt_len | output | LEN_W (11) | Header plus payload byte count of the completed packet |
| rd_addr | input | AW (10) | Packet buffer read address |
| rd_data | output | 8 | Packet buffer byte at rd_addr (combinational) |

## Verification
The assertions rely on the stream only ever being framed by the parser itself, so a completion can only follow an accepted byte. They also rely on at least three accepted bytes separating two completions, which the smallest legal frame guarantees. The stimulus drives in_valid and in_data away from the clock edge and leaves in_data meaningful only while in_valid is high. The buffer is read only while in_valid is held low, so no write races the read.

// File: rtl/hci_h4_pkg.sv
package hci_h4_pkg;

    typedef enum logic [1:0] {
        PH_TYPE = 2'd0,
        PH_HDR  = 2'd1,
        PH_PAY  = 2'd2
    } h4_phase_e;

    localparam logic [7:0] H4_CODE_EVT = 8'h04;
    localparam logic [7:0] H4_CODE_ACL = 8'h02;

    localparam int unsigned H4_EVT_HDR = 2;
    localparam int unsigned H4_ACL_HDR = 4;

endpackage

// File: rtl/h4_type_decode.sv
module h4_type_decode
    import hci_h4_pkg::*;
(
    input  logic [7:0] code,
    output logic       known,
    output logic       is_acl,
    output logic [2:0] hdr_bytes
);

    always_comb begin
        known     = 1'b0;
        is_acl    = 1'b0;
        hdr_bytes = 3'd0;
        unique case (code)
            H4_CODE_EVT: begin
                known     = 1'b1;
                hdr_bytes = 3'(H4_EVT_HDR);
            end
            H4_CODE_ACL: begin
                known     = 1'b1;
                is_acl    = 1'b1;
                hdr_bytes = 3'(H4_ACL_HDR);
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/h4_pkt_store.sv
module h4_pkt_store #(
    parameter int unsigned DEPTH = 1024,
    localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [7:0]    wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [7:0]    rd_data
);

    logic [7:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem_q[wr_addr] <= wr_data;
        end
    end

    always_comb begin
        if (32'(rd_addr) < DEPTH) begin
            rd_data = mem_q[rd_addr];
        end else begin
            rd_data = 8'h00;
        end
    end

endmodule

// File: rtl/hci_h4_deframer.sv
module hci_h4_deframer
    import hci_h4_pkg::*;
#(
    parameter int unsigned BUF_BYTES = 1024,
    localparam int unsigned AW       = (BUF_BYTES > 1) ? $clog2(BUF_BYTES) : 1,
    localparam int unsigned LEN_W    = $clog2(BUF_BYTES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [7:0]       in_data,
    output logic             in_ready,
    output logic             pkt_valid,
    output logic [7:0]       pkt_type,
    output logic [LEN_W-1:0] pkt_len,
    input  logic [AW-1:0]    rd_addr,
    output logic [7:0]       rd_data
);

    localparam int unsigned TW = 17;

    typedef struct packed {
        h4_phase_e        phase;
        logic             rdy;
        logic [7:0]       ptype;
        logic             is_acl;
        logic [2:0]       hsz;
        logic [AW-1:0]    idx;
        logic [7:0]       len_lo;
        logic [TW-1:0]    total;
        logic             pv;
        logic [LEN_W-1:0] plen;
    } dfr_state_t;

    dfr_state_t st_d, st_q;

    logic       dec_known, dec_acl;
    logic [2:0] dec_hdr;

    logic          wr_en;
    logic [AW-1:0] wr_addr;

    logic          accept;
    logic          last_hdr;
    logic [15:0]   hdr_len;
    logic [TW-1:0] hdr_total;
    logic [TW-1:0] idx_next;

    h4_type_decode u_dec (
        .code      (in_data),
        .known     (dec_known),
        .is_acl    (dec_acl),
        .hdr_bytes (dec_hdr)
    );

    h4_pkt_store #(.DEPTH(BUF_BYTES)) u_store (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (in_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

    always_comb begin
        st_d      = st_q;
        st_d.pv   = 1'b0;
        st_d.rdy  = 1'b1;
        wr_en     = 1'b0;
        wr_addr   = st_q.idx;

        accept    = in_valid && st_q.rdy;
        idx_next  = TW'(st_q.idx) + TW'(1);
        last_hdr  = (TW'(st_q.idx) + TW'(1)) == TW'(st_q.hsz);
        hdr_len   = st_q.is_acl ? {in_data, st_q.len_lo} : {8'h00, in_data};
        hdr_total = TW'(st_q.hsz) + TW'(hdr_len);

        unique case (st_q.phase)
            PH_TYPE: begin
                if (accept && dec_known) begin
                    st_d.ptype  = in_data;
                    st_d.is_acl = dec_acl;
                    st_d.hsz    = dec_hdr;
                    st_d.idx    = '0;
                    st_d.phase  = PH_HDR;
                end
            end
            PH_HDR: begin
                if (accept) begin
                    wr_en = 1'b1;
                    if (st_q.is_acl && st_q.idx == AW'(2)) begin
                        st_d.len_lo = in_data;
                    end
                    if (last_hdr) begin
                        if (hdr_total > TW'(BUF_BYTES)) begin
                            st_d.phase = PH_TYPE;
                        end else if (hdr_len == 16'd0) begin
                            st_d.pv    = 1'b1;
                            st_d.plen  = LEN_W'(st_q.hsz);
                            st_d.phase = PH_TYPE;
                        end else begin
                            st_d.total = hdr_total;
                            st_d.idx   = AW'(idx_next);
                            st_d.phase = PH_PAY;
                        end
                    end else begin
                        st_d.idx = AW'(idx_next);
                    end
                end
            end
            PH_PAY: begin
                if (accept) begin
                    wr_en = 1'b1;
                    if (idx_next == st_q.total) begin
                        st_d.pv    = 1'b1;
                        st_d.plen  = LEN_W'(st_q.total);
                        st_d.phase = PH_TYPE;
                    end else begin
                        st_d.idx = AW'(idx_next);
                    end
                end
            end
            default: begin
                st_d.phase = PH_TYPE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{phase: PH_TYPE, default: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign in_ready  = st_q.rdy;
    assign pkt_valid = st_q.pv;
    assign pkt_type  = st_q.ptype;
    assign pkt_len   = st_q.plen;

endmodule

// File: rtl/hci_h4_deframer_chk.sv
module hci_h4_deframer_chk #(
    parameter int unsigned BUF_BYTES = 1024,
    parameter int unsigned LEN_W     = 11
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             in_ready,
    input logic             pkt_valid,
    input logic [7:0]       pkt_type,
    input logic [LEN_W-1:0] pkt_len
);

    AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_valid |=> !pkt_valid); // R6

    AST_STROBE_AFTER_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_valid |-> $past(in_valid && in_ready)); // R9

    AST_TYPE_KNOWN: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_valid |-> (pkt_type == 8'h04 || pkt_type == 8'h02)); // R4

    AST_LEN_FITS: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_valid |-> (32'(pkt_len) <= BUF_BYTES)); // R5

    AST_LEN_HAS_HEADER: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_valid |-> ((pkt_type == 8'h04) ? (pkt_len >= LEN_W'(2)) : (pkt_len >= LEN_W'(4)))); // R8

    AST_READY_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |=> in_ready); // R1

endmodule

bind hci_h4_deframer hci_h4_deframer_chk #(
    .BUF_BYTES (BUF_BYTES),
    .LEN_W     (LEN_W)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .pkt_valid (pkt_valid),
    .pkt_type  (pkt_type),
    .pkt_len   (pkt_len)
);

// File: tb/hci_h4_deframer_tb_top.sv
module hci_h4_deframer_tb_top;

    localparam int BUF  = 1024;
    localparam int AW   = $clog2(BUF);
    localparam int LW   = $clog2(BUF + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [7:0]    in_data = 8'h00;
    logic          in_ready;
    logic          pkt_valid;
    logic [7:0]    pkt_type;
    logic [LW-1:0] pkt_len;
    logic [AW-1:0] rd_addr = '0;
    logic [7:0]    rd_data;

    always #10 clk = ~clk;

    hci_h4_deframer #(.BUF_BYTES(BUF)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .in_ready  (in_ready),
        .pkt_valid (pkt_valid),
        .pkt_type  (pkt_type),
        .pkt_len   (pkt_len),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data)
    );

    int checks = 0;
    int errors = 0;
    int pulses = 0;
    bit done   = 1'b0;

    // behavioural reference: phase 0 = hunt type, 1 = header, 2 = payload
    int         m_phase = 0;
    logic [7:0] m_type;
    int         m_hsz, m_cnt, m_tot, m_lo;
    logic [7:0] m_cur [$];
    logic [7:0] m_last [$];
    bit         e_pv = 1'b0;
    logic [7:0] e_type;
    int         e_len;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic model_byte(input logic [7:0] b);
        case (m_phase)
            0: begin
                if (b == 8'h04 || b == 8'h02) begin
                    m_type  = b;
                    m_hsz   = (b == 8'h04) ? 2 : 4;
                    m_cnt   = 0;
                    m_cur.delete();
                    m_phase = 1;
                end
            end
            1: begin
                int len;
                m_cur.push_back(b);
                m_cnt++;
                if (m_type == 8'h02 && m_cnt == 3) m_lo = b;
                if (m_cnt == m_hsz) begin
                    len   = (m_type == 8'h04) ? int'(b) : int'(b) * 256 + m_lo;
                    m_tot = m_hsz + len;
                    if (m_tot > BUF) begin
                        m_phase = 0;
                    end else if (len == 0) begin
                        e_pv = 1'b1; e_type = m_type; e_len = m_cnt;
                        m_last = m_cur; m_phase = 0;
                    end else begin
                        m_phase = 2;
                    end
                end
            end
            default: begin
                m_cur.push_back(b);
                m_cnt++;
                if (m_cnt == m_tot) begin
                    e_pv = 1'b1; e_type = m_type; e_len = m_cnt;
                    m_last = m_cur; m_phase = 0;
                end
            end
        endcase
    endtask

    // compare last edge's result, then drive the next input
    task automatic step(input bit v, input logic [7:0] b);
        @(negedge clk);
        if (pkt_valid) pulses++;
        chk(pkt_valid == e_pv, "R6 pkt_valid", int'(pkt_valid), int'(e_pv));
        if (e_pv && pkt_valid) begin
            chk(pkt_type == e_type, "R6 pkt_type", int'(pkt_type), int'(e_type));
            chk(int'(pkt_len) == e_len, (e_type == 8'h04) ? "R2 event pkt_len" : "R3 acl pkt_len",
                int'(pkt_len), e_len);
        end
        e_pv     = 1'b0;
        in_valid = v;
        in_data  = v ? b : 8'hxx;
        if (v && in_ready) model_byte(b);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b0, 8'h00);
    endtask

    task automatic send_hdr_and_pay(input logic [7:0] t, input int hsz, input int len,
                                    input int seed, input int gap);
        logic [7:0] hb [4];
        for (int i = 0; i < 4; i++) hb[i] = 8'(seed + 17 * i);
        if (hsz == 2) begin
            hb[1] = 8'(len);
        end else begin
            hb[2] = 8'(len);
            hb[3] = 8'(len >> 8);
        end
        step(1'b1, t);
        for (int i = 0; i < hsz; i++) begin
            step(1'b1, hb[i]);
            if (gap > 0 && i % gap == 0) idle(1);
        end
        for (int i = 0; i < len; i++) begin
            step(1'b1, 8'(seed * 3 + i * 7));
            if (gap > 0 && i % gap == 1) idle(2);
        end
    endtask

    task automatic check_buf(input string tag);
        in_valid = 1'b0;
        for (int i = 0; i < m_last.size(); i++) begin
            rd_addr = AW'(i);
            #1;
            chk(rd_data == m_last[i], tag, int'(rd_data), int'(m_last[i]));
        end
    endtask

    initial begin
        int p0;
        repeat (3) @(negedge clk);
        chk(pkt_valid == 1'b0, "R1 pkt_valid in reset", int'(pkt_valid), 0);
        chk(in_ready == 1'b0, "R1 in_ready in reset", int'(in_ready), 0);
        rst_n = 1'b1;
        idle(2);
        chk(in_ready == 1'b1, "R1 in_ready after reset", int'(in_ready), 1);

        // R2: event with payload
        send_hdr_and_pay(8'h04, 2, 5, 11, 0);
        idle(2);
        check_buf("R7 event buffer");

        // R3: ACL with two-byte little-endian length
        send_hdr_and_pay(8'h02, 4, 300, 23, 0);
        idle(2);
        check_buf("R7 acl buffer");

        // R8: zero-length event and zero-length ACL
        p0 = pulses;
        send_hdr_and_pay(8'h04, 2, 0, 5, 0);
        idle(2);
        chk(pulses == p0 + 1, "R8 zero-length event strobes", pulses - p0, 1);
        send_hdr_and_pay(8'h02, 4, 0, 9, 0);
        idle(2);
        check_buf("R8 zero-length acl header stored");

        // R4: unknown type bytes discarded, then an event parses
        p0 = pulses;
        step(1'b1, 8'h01);
        step(1'b1, 8'h03);
        step(1'b1, 8'hFF);
        idle(2);
        chk(pulses == p0, "R4 no strobe on unknown type", pulses - p0, 0);
        send_hdr_and_pay(8'h04, 2, 3, 41, 0);
        idle(2);
        chk(pulses == p0 + 1, "R4 resync after unknown type", pulses - p0, 1);

        // R5: oversize ACL dropped (4 + 1021 > 1024), next type byte parsed
        p0 = pulses;
        send_hdr_and_pay(8'h02, 4, 0, 0, 0);
        idle(1);
        p0 = pulses;
        step(1'b1, 8'h02);
        step(1'b1, 8'h10); step(1'b1, 8'h20);
        step(1'b1, 8'hFD); step(1'b1, 8'h03);
        idle(3);
        chk(pulses == p0, "R5 oversize dropped", pulses - p0, 0);
        send_hdr_and_pay(8'h04, 2, 4, 61, 0);
        idle(2);
        chk(pulses == p0 + 1, "R5 resync after drop", pulses - p0, 1);

        // R5 boundary: 4 + 1020 == 1024 accepted
        p0 = pulses;
        send_hdr_and_pay(8'h02, 4, BUF - 4, 77, 0);
        idle(2);
        chk(pulses == p0 + 1, "R5 exact-fit accepted", pulses - p0, 1);
        check_buf("R7 full buffer");

        // R9: idle gaps inside frames
        p0 = pulses;
        send_hdr_and_pay(8'h04, 2, 9, 91, 1);
        idle(1);
        send_hdr_and_pay(8'h02, 4, 7, 93, 2);
        idle(2);
        chk(pulses == p0 + 2, "R9 gaps keep frames", pulses - p0, 2);
        check_buf("R9 gapped buffer");

        // back-to-back frames without idle cycles
        send_hdr_and_pay(8'h04, 2, 1, 3, 0);
        send_hdr_and_pay(8'h04, 2, 0, 4, 0);
        send_hdr_and_pay(8'h02, 4, 2, 6, 0);
        idle(3);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule